// File: doc/BRIEF.md
# UART Receive Byte Queue with Idle Time-Out

This block is the receive-side byte store of a serial port. A deserializer hands it one byte per strobe. The CPU side reads the oldest byte from a read port and removes it with a pop strobe. The queue holds up to sixteen bytes. It reports its current fill level together with empty, full and overflow indications.

Two service flags help the CPU decide when to drain the queue. The data-ready flag is level-sensitive. It is high while the fill level is at or above a threshold picked by a 2-bit select, and it drops by itself when reads bring the level back under that threshold. The idle flag is raised when bytes are waiting and the line has shown no queue activity for a programmed number of baud ticks. The idle flag stays up until the CPU pops a byte.

A one-cycle software reset request empties the queue and clears all receive state. The request starts a fixed hold window, and the busy indication drops by itself when the window ends.

The idle timer is a three-state machine:
- TMR_EMPTY: the queue is empty and ticks are ignored. It moves to TMR_COUNT once the queue holds data.
- TMR_COUNT: ticks are counted, and any push or pop restarts the count. It returns to TMR_EMPTY when the queue is empty and idle. It moves to TMR_FIRED on the tick that completes the limit.
- TMR_FIRED: the idle flag is up. It goes back to TMR_COUNT on an accepted pop.

The reset sequencer has two states. SR_IDLE moves to SR_HOLD on a request. SR_HOLD returns to SR_IDLE after its cycle count runs out. A reset request forces the timer into TMR_EMPTY.

Top module: `rxq_timeout_fifo`

## Requirements
- R1: `level_o` rises by one for every accepted push and falls by one for every accepted pop. When both are accepted in the same cycle it is unchanged. Bytes leave in arrival order, and `pop_data_o` shows the oldest stored byte whenever the queue is not empty. Outputs reflect a strobe in the cycle after the clock edge that samples it.
- R2: `full_o` is 1 exactly when `level_o` equals 16.
- R3: `empty_o` is 1 exactly when `level_o` is 0. A pop while empty has no effect.
- R4: A push that arrives while the queue holds 16 bytes is dropped. The stored bytes and the level are unchanged, and `ovf_o` is set. This holds even if a pop is accepted in the same cycle. `ovf_o` stays set until `ovf_clr_i` is 1 at a clock edge. A new overflow in that same cycle wins over the clear.
- R5: `avail_o` is 1 exactly when `level_o` is at or above the threshold chosen by `trig_sel_i`. The encodings are 0 = 1 byte, 1 = 4 bytes, 2 = 8 bytes and 3 = 14 bytes.
- R6: With `to_limit_i` = N and N not zero, `timeout_o` sets on the (N+1)-th baud tick that follows the last push or pop, provided the queue is not empty. With N = 0 the flag never sets.
- R7: `timeout_o` is cleared only by an accepted pop or a software reset. A push does not clear it, and neither do more ticks. Before the flag fires, a push or pop restarts the tick count.
- R8: A one-cycle pulse on `srst_req_i` makes `srst_busy_o` high for exactly 3 cycles, starting in the cycle after the request. While busy, pushes and pops are ignored. When busy falls, the queue is empty and `ovf_o` and `timeout_o` are 0.
- R9: Baud ticks that arrive while the queue is empty do not count toward the time-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Received-byte strobe |
| push_data_i | input | 8 | Received byte |
| pop_i | input | 1 | CPU read strobe, removes the oldest byte |
| pop_data_o | output | 8 | Oldest stored byte (0 when empty) |
| baud_tick_i | input | 1 | One-cycle baud clock tick |
| trig_sel_i | input | 2 | Data-ready threshold select |
| to_limit_i | input | 9 | Idle time-out compare value, 0 disables |
| ovf_clr_i | input | 1 | Write-one-to-clear for the overflow flag |
| srst_req_i | input | 1 | Software receive reset request |
| level_o | output | 5 | Number of stored bytes |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue holds 16 bytes |
| ovf_o | output | 1 | Sticky overflow flag |
| avail_o | output | 1 | Data-ready flag |
| timeout_o | output | 1 | Idle time-out flag |
| srst_busy_o | output | 1 | Software reset in progress |

## Verification
Some checks run on every cycle. They cover the level stepping for single pushes and pops, pops on an empty queue having no effect, and a push into a full queue setting the sticky overflow flag while the level stays put. They also check that the idle flag is never up with an empty queue, never sets while disabled and drops after a pop, and that a software reset leaves an empty queue with both flags clear.

Other behaviour depends on a history of operations, so only the bench scenarios can show it. These scenarios check byte order across a full wrap and that a dropped byte never shows up. They check the exact tick on which the idle flag rises, that a push restarts the count, and that ticks seen while empty are ignored. They also check the threshold boundaries and the exact length of the reset window.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

    typedef enum logic [1:0] {
        TMR_EMPTY = 2'd0,
        TMR_COUNT = 2'd1,
        TMR_FIRED = 2'd2
    } tmr_state_e;

    typedef enum logic {
        SR_IDLE = 1'b0,
        SR_HOLD = 1'b1
    } sr_state_e;

    // Data-ready threshold for a given select code and queue depth.
    function automatic int trig_threshold(input logic [1:0] sel, input int depth);
        int thr;
        unique case (sel)
            2'd0:    thr = 1;
            2'd1:    thr = depth / 4;
            2'd2:    thr = depth / 2;
            default: thr = depth - 2;
        endcase
        return thr;
    endfunction

endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          rd_i,
    output logic [DW-1:0] rd_data_o,
    output logic [CW-1:0] level_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          wr_acc_o,
    output logic          rd_acc_o
);
    localparam int            PW       = $clog2(DEPTH);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;

    always_comb begin
        full_o   = (count == FULL_CNT);
        empty_o  = (count == '0);
        wr_acc_o = wr_i && !flush_i && !full_o;
        rd_acc_o = rd_i && !flush_i && !empty_o;
        level_o  = count;
        rd_data_o = empty_o ? '0 : mem[rd_ptr];
    end

    // One write-enabled register per entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (wr_acc_o && (wr_ptr == PW'(g))) begin
                mem[g] <= wr_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_acc_o) wr_ptr <= wr_ptr + 1'b1;
            if (rd_acc_o) rd_ptr <= rd_ptr + 1'b1;
            unique case ({wr_acc_o, rd_acc_o})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/rxq_idle_timer.sv
`timescale 1ns/1ps
module rxq_idle_timer #(
    parameter int TOW = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           flush_i,
    input  logic           active_i,
    input  logic           pop_i,
    input  logic           has_data_i,
    input  logic           tick_i,
    input  logic [TOW-1:0] limit_i,
    output logic           fired_o
);
    import rxq_pkg::*;

    tmr_state_e     state, state_nxt;
    logic [TOW-1:0] idle_cnt;
    logic           limit_on;
    logic           limit_hit;

    always_comb begin
        limit_on  = (limit_i != '0);
        limit_hit = limit_on && tick_i && !active_i && (idle_cnt >= limit_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TMR_EMPTY;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (flush_i) begin
            state_nxt = TMR_EMPTY;
        end else begin
            unique case (state)
                TMR_EMPTY: if (has_data_i) state_nxt = TMR_COUNT;
                TMR_COUNT: begin
                    if (!has_data_i && !active_i) state_nxt = TMR_EMPTY;
                    else if (limit_hit)           state_nxt = TMR_FIRED;
                end
                TMR_FIRED: if (pop_i) state_nxt = TMR_COUNT;
                default:   state_nxt = TMR_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (flush_i || (state != TMR_COUNT) || active_i) begin
            idle_cnt <= '0;
        end else if (tick_i && limit_on && !limit_hit) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    always_comb begin
        fired_o = (state == TMR_FIRED);
    end

endmodule

// File: rtl/rxq_soft_reset.sv
`timescale 1ns/1ps
module rxq_soft_reset #(
    parameter int HOLD_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic busy_o
);
    import rxq_pkg::*;

    localparam int HW = $clog2(HOLD_CYC + 1);

    sr_state_e     state, state_nxt;
    logic [HW-1:0] hold_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SR_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            SR_IDLE: if (req_i) state_nxt = SR_HOLD;
            SR_HOLD: if (hold_cnt == '0) state_nxt = SR_IDLE;
            default: state_nxt = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (state == SR_IDLE) begin
            if (req_i) hold_cnt <= HW'(HOLD_CYC - 1);
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    always_comb begin
        busy_o = (state == SR_HOLD);
    end

endmodule

// File: rtl/rxq_timeout_fifo.sv
`timescale 1ns/1ps
module rxq_timeout_fifo #(
    parameter int DEPTH    = 16,
    parameter int DW       = 8,
    parameter int TOW      = 9,
    parameter int SRST_CYC = 3,
    parameter int CW       = $clog2(DEPTH) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push_i,
    input  logic [DW-1:0]  push_data_i,
    input  logic           pop_i,
    output logic [DW-1:0]  pop_data_o,
    input  logic           baud_tick_i,
    input  logic [1:0]     trig_sel_i,
    input  logic [TOW-1:0] to_limit_i,
    input  logic           ovf_clr_i,
    input  logic           srst_req_i,
    output logic [CW-1:0]  level_o,
    output logic           empty_o,
    output logic           full_o,
    output logic           ovf_o,
    output logic           avail_o,
    output logic           timeout_o,
    output logic           srst_busy_o
);
    logic          flush;
    logic          wr_acc;
    logic          rd_acc;
    logic [CW-1:0] thr_lvl;
    logic          ovf_q;

    rxq_soft_reset #(.HOLD_CYC(SRST_CYC)) u_srst (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (srst_req_i),
        .busy_o (flush)
    );

    rxq_store #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush),
        .wr_i      (push_i),
        .wr_data_i (push_data_i),
        .rd_i      (pop_i),
        .rd_data_o (pop_data_o),
        .level_o   (level_o),
        .full_o    (full_o),
        .empty_o   (empty_o),
        .wr_acc_o  (wr_acc),
        .rd_acc_o  (rd_acc)
    );

    rxq_idle_timer #(.TOW(TOW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush),
        .active_i   (wr_acc || rd_acc),
        .pop_i      (rd_acc),
        .has_data_i (!empty_o),
        .tick_i     (baud_tick_i),
        .limit_i    (to_limit_i),
        .fired_o    (timeout_o)
    );

    // Sticky overflow: a dropped byte wins over a same-cycle clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  ovf_q <= 1'b0;
        else if (flush)              ovf_q <= 1'b0;
        else if (push_i && full_o)   ovf_q <= 1'b1;
        else if (ovf_clr_i)          ovf_q <= 1'b0;
    end

    always_comb begin
        thr_lvl     = CW'(rxq_pkg::trig_threshold(trig_sel_i, DEPTH));
        avail_o     = (level_o >= thr_lvl);
        ovf_o       = ovf_q;
        srst_busy_o = flush;
    end

endmodule

// File: rtl/rxq_timeout_fifo_chk.sv
`timescale 1ns/1ps
module rxq_timeout_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_i,
    input logic          pop_i,
    input logic          ovf_clr_i,
    input logic          to_limit_zero,
    input logic [CW-1:0] level_o,
    input logic          empty_o,
    input logic          full_o,
    input logic          ovf_o,
    input logic          timeout_o,
    input logic          srst_busy_o
);
    a_r1_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && !full_o && !pop_i && !srst_busy_o |=> level_o == $past(level_o) + 1'b1);

    a_r1_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && !empty_o && !push_i && !srst_busy_o |=> level_o == $past(level_o) - 1'b1);

    a_r3_pop_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && empty_o && !push_i |=> empty_o);

    a_r4_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && full_o && !srst_busy_o |=> ovf_o);

    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o && !ovf_clr_i && !srst_busy_o |=> ovf_o);

    a_r4_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && full_o && !pop_i && !srst_busy_o |=> level_o == CW'(DEPTH));

    a_r6_timeout_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !empty_o);

    a_r6_disabled_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        to_limit_zero && !timeout_o |=> !timeout_o);

    a_r7_pop_clears_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && !empty_o && !srst_busy_o |=> !timeout_o);

    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srst_busy_o) |=> srst_busy_o);

    a_r8_flush_result: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srst_busy_o) |-> (level_o == '0) && !ovf_o && !timeout_o);

endmodule

bind rxq_timeout_fifo rxq_timeout_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .push_i        (push_i),
    .pop_i         (pop_i),
    .ovf_clr_i     (ovf_clr_i),
    .to_limit_zero (to_limit_i == '0),
    .level_o       (level_o),
    .empty_o       (empty_o),
    .full_o        (full_o),
    .ovf_o         (ovf_o),
    .timeout_o     (timeout_o),
    .srst_busy_o   (srst_busy_o)
);

// File: tb/rxq_timeout_fifo_tb_top.sv
`timescale 1ns/1ps
module rxq_timeout_fifo_tb_top;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_i = 1'b0;
    logic [7:0] push_data_i = '0;
    logic       pop_i = 1'b0;
    logic [7:0] pop_data_o;
    logic       baud_tick_i = 1'b0;
    logic [1:0] trig_sel_i = '0;
    logic [8:0] to_limit_i = '0;
    logic       ovf_clr_i = 1'b0;
    logic       srst_req_i = 1'b0;
    logic [4:0] level_o;
    logic       empty_o, full_o, ovf_o, avail_o, timeout_o, srst_busy_o;

    always #2 clk = ~clk;

    rxq_timeout_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
        .pop_i(pop_i), .pop_data_o(pop_data_o), .baud_tick_i(baud_tick_i),
        .trig_sel_i(trig_sel_i), .to_limit_i(to_limit_i), .ovf_clr_i(ovf_clr_i),
        .srst_req_i(srst_req_i), .level_o(level_o), .empty_o(empty_o),
        .full_o(full_o), .ovf_o(ovf_o), .avail_o(avail_o),
        .timeout_o(timeout_o), .srst_busy_o(srst_busy_o)
    );

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 0;
    byte unsigned mq[$];
    bit  m_ovf = 0;

    function automatic int thr_of(int sel);
        case (sel)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, return at the next falling edge.
    task automatic cyc(bit p, byte unsigned d, bit r, bit t, bit clr, bit sr);
        push_i = p; push_data_i = d; pop_i = r; baud_tick_i = t;
        ovf_clr_i = clr; srst_req_i = sr;
        @(posedge clk);
        @(negedge clk);
        push_i = 0; pop_i = 0; baud_tick_i = 0; ovf_clr_i = 0; srst_req_i = 0;
    endtask

    task automatic check_all();
        int sz = mq.size();
        chk("R1 level", int'(level_o), sz);
        chk("R2 full", int'(full_o), int'(sz == DEPTH));
        chk("R3 empty", int'(empty_o), int'(sz == 0));
        chk("R4 ovf", int'(ovf_o), int'(m_ovf));
        chk("R5 avail", int'(avail_o), int'(sz >= thr_of(int'(trig_sel_i))));
        if (sz > 0) chk("R1 head data", int'(pop_data_o), int'(mq[0]));
    endtask

    task automatic op(bit p, byte unsigned d, bit r, bit clr);
        bit was_full = (mq.size() == DEPTH);
        cyc(p, d, r, 0, clr, 0);
        if (r && mq.size() > 0) void'(mq.pop_front());
        if (p && !was_full) mq.push_back(d);
        if (p && was_full) m_ovf = 1;
        else if (clr) m_ovf = 0;
        check_all();
    endtask

    task automatic tk();
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        check_all();
        chk("R6 reset timeout", int'(timeout_o), 0);
        chk("R8 reset busy", int'(srst_busy_o), 0);

        // Fill with the top threshold selected: R5 boundary at 13 and 14
        trig_sel_i = 2'd3;
        for (int i = 0; i < DEPTH; i++) op(1, byte'(8'h10 + i), 0, 0);
        for (int s = 0; s < 3; s++) begin
            trig_sel_i = 2'(s);
            #0 check_all();
        end

        // R4 overflow: byte dropped, set wins over clear, then cleared
        op(1, 8'hEE, 0, 0);
        op(1, 8'hED, 1, 1);
        op(0, 0, 0, 1);
        chk("R4 ovf cleared", int'(ovf_o), 0);
        while (mq.size() > 0) op(0, 0, 1, 0);
        op(0, 0, 1, 0);   // R3 pop on empty

        // Idle time-out, limit 3
        to_limit_i = 9'd3;
        for (int i = 0; i < 10; i++) tk();   // R9 ticks while empty
        op(1, 8'hA1, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) tk();
        chk("R6 R9 not yet after 3 ticks", int'(timeout_o), 0);
        tk();
        chk("R6 set on 4th tick", int'(timeout_o), 1);
        op(1, 8'hA2, 0, 0);
        chk("R7 push keeps flag", int'(timeout_o), 1);
        tk(); tk();
        chk("R7 ticks keep flag", int'(timeout_o), 1);
        op(0, 0, 1, 0);
        chk("R7 pop clears flag", int'(timeout_o), 0);
        tk(); tk();
        op(1, 8'hA3, 0, 0);
        for (int i = 0; i < 3; i++) tk();
        chk("R7 push restarted count", int'(timeout_o), 0);
        tk();
        chk("R7 set after restart", int'(timeout_o), 1);
        while (mq.size() > 0) op(0, 0, 1, 0);
        chk("R7 cleared after drain", int'(timeout_o), 0);

        // Limit 0 disables
        to_limit_i = 9'd0;
        op(1, 8'h5A, 0, 0);
        for (int i = 0; i < 20; i++) tk();
        chk("R6 disabled", int'(timeout_o), 0);

        // Software reset with data, overflow and time-out pending
        while (mq.size() < DEPTH) op(1, byte'($urandom), 0, 0);
        op(1, 8'h77, 0, 0);
        to_limit_i = 9'd1;
        tk(); tk();
        chk("R6 limit 1 fired", int'(timeout_o), 1);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R8 busy cycle 1", int'(srst_busy_o), 1);
        cyc(1, 8'h01, 1, 0, 0, 0);
        chk("R8 busy cycle 2", int'(srst_busy_o), 1);
        cyc(1, 8'h02, 1, 0, 0, 0);
        chk("R8 busy cycle 3", int'(srst_busy_o), 1);
        cyc(1, 8'h03, 0, 0, 0, 0);
        chk("R8 busy ended", int'(srst_busy_o), 0);
        mq.delete();
        m_ovf = 0;
        check_all();
        chk("R8 timeout cleared", int'(timeout_o), 0);

        // Constrained random traffic
        to_limit_i = 9'd0;
        for (int i = 0; i < 3000; i++) begin
            int pp = (i < 1000) ? 70 : ((i < 2000) ? 50 : 25);
            bit p = ($urandom % 100) < pp;
            bit r = ($urandom % 100) < (100 - pp);
            bit c = ($urandom % 100) < 5;
            trig_sel_i = 2'($urandom % 4);
            op(p, byte'($urandom), r, c);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule